// File: doc/BRIEF.md
# DMA Channel Count and Acknowledge Controller

This block is the control core of a single DMA transfer channel. Software loads a transfer count and sets an enable bit. The block then decrements the count by one for each completed transfer unit. When the remaining count falls to half of the value held at enable time, a sticky half-point flag is raised. If the half-point interrupt enable is set, the flag drives an interrupt request. When the count reaches zero, a finish flag is raised and the channel clears its own enable bit.

The block also drives an external acknowledge strobe for each transfer cycle. In single-address mode the strobe fires on every transfer cycle. In dual-address mode a control bit chooses whether it fires during the read phase or the write phase. A second control bit chooses its polarity. A parameter removes these two bits, so that they read as zero and ignore writes.

Top module: `dma_half_chan`

## Requirements
- R1: After a synchronous reset, the count register reads 0, the control register reads 0, `irq` is 0 and `ack` is 1 (the idle level for active-low).
- R2: A control write that sets the enable bit (bit 0) while it is clear captures the current count as the starting count. Each `unit_done` pulse while enabled with a nonzero count lowers the count by 1. A `unit_done` pulse while disabled leaves the count unchanged.
- R3: The half-point flag (control bit 2) is set on the clock edge at which the count becomes the starting count shifted right by one. It is set at most once per enabled run.
- R4: The half-point flag stays set until software writes 0 to bit 2. Writing 1 to bit 2 leaves it unchanged. The finish flag (bit 3) is cleared the same way.
- R5: `irq` is registered. It is 1 one cycle after the half-point flag and the interrupt enable (bit 1) are both 1. It is 0 one cycle after either of them is 0.
- R6: On the edge at which the count becomes 0, the finish flag (bit 3) is set and the enable bit is cleared.
- R7: With a starting count of 1, the half-point flag and the finish flag are set on the same edge.
- R8: In dual-address mode (`single_mode`=0), the strobe is active during transfer cycles whose `phase_wr` equals the mode bit (bit 4): 0 selects the read phase and 1 selects the write phase. `ack` follows with one register of delay.
- R9: In single-address mode, the strobe is active on every transfer cycle, whatever the phase and the mode bit.
- R10: Polarity bit 5 set to 0 gives an active level of 0 and an idle level of 1. Bit 5 set to 1 gives an active level of 1 and an idle level of 0.
- R11: With `HAS_ACK_CFG`=0, bits 4 and 5 read as 0 and ignore writes, so the strobe acts as read-phase and active-low.
- R12: The strobe stays at its idle level unless the channel is enabled and `xfer_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = count, 1 = control |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data of the selected register |
| unit_done | input | 1 | One-cycle pulse per completed transfer unit |
| xfer_active | input | 1 | A transfer bus cycle is in progress |
| phase_wr | input | 1 | Phase of the current cycle: 0 = read, 1 = write |
| single_mode | input | 1 | 1 = single-address mode, 0 = dual-address mode |
| irq | output | 1 | Half-point interrupt request |
| ack | output | 1 | Acknowledge strobe |

## Verification
The bench targets odd and even starting counts. An off-by-one in the half-point compare would flag one unit too early or too late. The starting-count-of-one case must raise both flags on one edge. A design that gated the half-point compare on a nonzero result would miss it there. The bench also checks that the half-point flag does not fire again later in the run, that writing 1 does not clear a flag, and that `irq` lags the flag by exactly one cycle. The strobe table crosses phase, mode, polarity and address mode. A design with inverted polarity, a swapped phase select, or an ignored single-address override fails at least one row. The instance without acknowledge configuration must read 0 in bits 4 and 5 even after 1s are written to them.

// File: rtl/dma_half_pkg.sv
package dma_half_pkg;
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_IE   = 1;
  localparam int unsigned BIT_HALF = 2;
  localparam int unsigned BIT_END  = 3;
  localparam int unsigned BIT_MODE = 4;
  localparam int unsigned BIT_LVL  = 5;
  localparam int unsigned CTRL_W   = 6;

  typedef struct packed {
    logic lvl;
    logic mode;
    logic fin;
    logic half;
    logic ie;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/dma_half_ctrl.sv
module dma_half_ctrl
  import dma_half_pkg::*;
#(
  parameter bit HAS_ACK_CFG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              hit_half,
  input  logic              hit_end,
  output ctrl_t             ctrl,
  output logic              en_rise
);
  logic en_q, ie_q, half_q, fin_q;

  assign en_rise = wr && wdata[BIT_EN] && !en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      half_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      // software writes first, hardware events take priority
      if (hit_end)  en_q <= 1'b0;
      else if (wr)  en_q <= wdata[BIT_EN];
      if (wr)       ie_q <= wdata[BIT_IE];
      half_q <= (wr ? (half_q & wdata[BIT_HALF]) : half_q) | hit_half;
      fin_q  <= (wr ? (fin_q & wdata[BIT_END]) : fin_q) | hit_end;
    end
  end

  logic mode_w, lvl_w;

  generate
    if (HAS_ACK_CFG) begin : g_cfg
      logic mode_q, lvl_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          mode_q <= 1'b0;
          lvl_q  <= 1'b0;
        end else if (wr) begin
          mode_q <= wdata[BIT_MODE];
          lvl_q  <= wdata[BIT_LVL];
        end
      end
      assign mode_w = mode_q;
      assign lvl_w  = lvl_q;
    end else begin : g_nocfg
      assign mode_w = 1'b0;
      assign lvl_w  = 1'b0;
    end
  endgenerate

  assign ctrl = '{lvl: lvl_w, mode: mode_w, fin: fin_q, half: half_q, ie: ie_q, en: en_q};
endmodule

// File: rtl/dma_half_count.sv
module dma_half_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             en,
  input  logic             en_rise,
  input  logic             unit_done,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] half_tgt,
  output logic             hit_half,
  output logic             hit_end
);
  logic [CNT_W-1:0] cnt_q, start_q, nxt;
  logic             fired_q, dec;

  assign dec      = unit_done && en && (cnt_q != '0);
  assign nxt      = cnt_q - 1'b1;
  assign half_tgt = start_q >> 1;
  assign hit_end  = dec && (nxt == '0);
  assign hit_half = dec && !fired_q && (nxt == half_tgt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      start_q <= '0;
      fired_q <= 1'b0;
    end else begin
      if (wr)       cnt_q <= wdata;
      else if (dec) cnt_q <= nxt;
      if (en_rise) begin
        start_q <= cnt_q;
        fired_q <= 1'b0;
      end else if (hit_half) begin
        fired_q <= 1'b1;
      end
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dma_half_ack.sv
module dma_half_ack (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic xfer_active,
  input  logic phase_wr,
  input  logic single_mode,
  input  logic mode,
  input  logic lvl,
  output logic ack
);
  logic act;

  assign act = en && xfer_active && (single_mode || (phase_wr == mode));

  always_ff @(posedge clk) begin
    if (rst) ack <= 1'b1;
    else     ack <= lvl ? act : !act;
  end
endmodule

// File: rtl/dma_half_chan.sv
module dma_half_chan
  import dma_half_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter bit          HAS_ACK_CFG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             unit_done,
  input  logic             xfer_active,
  input  logic             phase_wr,
  input  logic             single_mode,
  output logic             irq,
  output logic             ack
);
  ctrl_t            ctrl;
  logic             en_rise, hit_half, hit_end;
  logic [CNT_W-1:0] cnt, half_tgt;
  logic             ctrl_wr, cnt_wr;

  assign ctrl_wr = reg_wr && reg_sel;
  assign cnt_wr  = reg_wr && !reg_sel;

  dma_half_ctrl #(.HAS_ACK_CFG(HAS_ACK_CFG)) u_ctrl (
    .clk(clk), .rst(rst), .wr(ctrl_wr), .wdata(reg_wdata[CTRL_W-1:0]),
    .hit_half(hit_half), .hit_end(hit_end), .ctrl(ctrl), .en_rise(en_rise)
  );

  dma_half_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .wr(cnt_wr), .wdata(reg_wdata), .en(ctrl.en),
    .en_rise(en_rise), .unit_done(unit_done), .cnt(cnt), .half_tgt(half_tgt),
    .hit_half(hit_half), .hit_end(hit_end)
  );

  dma_half_ack u_ack (
    .clk(clk), .rst(rst), .en(ctrl.en), .xfer_active(xfer_active),
    .phase_wr(phase_wr), .single_mode(single_mode), .mode(ctrl.mode),
    .lvl(ctrl.lvl), .ack(ack)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ctrl.half && ctrl.ie;
  end

  assign reg_rdata = reg_sel ? {{(CNT_W-CTRL_W){1'b0}}, ctrl} : cnt;
endmodule

// File: rtl/dma_half_chk.sv
module dma_half_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic             unit_done,
  input logic             xfer_active,
  input logic             irq,
  input logic             ack,
  input logic             en,
  input logic             ie,
  input logic             half,
  input logic             fin,
  input logic             lvl,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] half_tgt
);
  assert_dec_R2: assert property (@(posedge clk) disable iff (rst)
    (unit_done && en && cnt != '0 && !reg_wr) |=> (cnt == $past(cnt) - 1'b1));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!en && !reg_wr) |=> $stable(cnt));

  assert_half_pt_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(half) |-> (cnt == half_tgt));

  assert_irq_lag_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(half && ie)));

  assert_end_off_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(fin) |-> (!en && cnt == '0));

  assert_ack_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (!(en && xfer_active) && !reg_wr) |=> (ack == !lvl));
endmodule

bind dma_half_chan dma_half_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .unit_done(unit_done),
  .xfer_active(xfer_active), .irq(irq), .ack(ack), .en(ctrl.en), .ie(ctrl.ie),
  .half(ctrl.half), .fin(ctrl.fin), .lvl(ctrl.lvl), .cnt(cnt), .half_tgt(half_tgt)
);

// File: tb/dma_half_chan_bench.sv
`timescale 1ns/1ps
module dma_half_chan_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wr = 1'b0, reg_sel = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] rdata, n_rdata;
  logic         unit_done = 1'b0, xfer_active = 1'b0, phase_wr = 1'b0, single_mode = 1'b0;
  logic         irq, ack, n_irq, n_ack;
  int           errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  dma_half_chan #(.CNT_W(W), .HAS_ACK_CFG(1'b1)) u_dma_half_chan (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(rdata), .unit_done(unit_done), .xfer_active(xfer_active),
    .phase_wr(phase_wr), .single_mode(single_mode), .irq(irq), .ack(ack));

  dma_half_chan #(.CNT_W(W), .HAS_ACK_CFG(1'b0)) u_nocfg (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(n_rdata), .unit_done(unit_done), .xfer_active(xfer_active),
    .phase_wr(phase_wr), .single_mode(single_mode), .irq(n_irq), .ack(n_ack));

  // {single, phase_wr, mode, lvl, expected ack}
  localparam logic [4:0] VEC [8] = '{
    5'b0_0_0_0_0, 5'b0_1_0_0_1, 5'b0_0_1_0_1, 5'b0_1_1_0_0,
    5'b0_0_0_1_1, 5'b0_1_0_1_0, 5'b1_1_0_1_1, 5'b1_0_1_0_0};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input int data);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = W'(data);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output int val);
    reg_sel = sel; #0.5;
    val = int'(rdata);
  endtask

  task automatic pulse();
    unit_done = 1'b1;
    @(negedge clk);
    unit_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd(1'b0, v); chk("R1 count", v, 0);
    rd(1'b1, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ack", ack, 1);

    // even start count 6, half point 3
    wr(1'b0, 6);
    wr(1'b1, 'h03);
    pulse(); pulse();
    rd(1'b0, v); chk("R2 dec", v, 4);
    rd(1'b1, v); chk("R3 not early", (v >> 2) & 1, 0);
    pulse();
    rd(1'b1, v); chk("R3 half at 3", (v >> 2) & 1, 1);
    chk("R5 irq lag", irq, 0);
    @(negedge clk);
    chk("R5 irq set", irq, 1);
    wr(1'b1, 'h07);
    rd(1'b1, v); chk("R4 write1 keeps", (v >> 2) & 1, 1);
    wr(1'b1, 'h03);
    rd(1'b1, v); chk("R4 write0 clears", (v >> 2) & 1, 0);
    @(negedge clk);
    chk("R5 irq drops", irq, 0);
    pulse(); pulse(); pulse();
    rd(1'b1, v); chk("R6 end, en off, R3 once", v, 'h0A);
    rd(1'b0, v); chk("R6 count zero", v, 0);
    pulse();
    rd(1'b0, v); chk("R2 disabled hold", v, 0);

    // start count 1
    wr(1'b1, 'h00);
    wr(1'b0, 1);
    wr(1'b1, 'h01);
    pulse();
    rd(1'b1, v); chk("R7 both flags", v, 'h0C);

    // odd start count 5, half point 2
    wr(1'b1, 'h00);
    wr(1'b0, 5);
    wr(1'b1, 'h01);
    pulse(); pulse();
    rd(1'b1, v); chk("R3 odd not early", (v >> 2) & 1, 0);
    pulse();
    rd(1'b1, v); chk("R3 odd half at 2", (v >> 2) & 1, 1);
    wr(1'b1, 'h00);
    wr(1'b0, 9);
    pulse();
    rd(1'b0, v); chk("R2 disabled ignore", v, 9);

    // acknowledge table
    for (int i = 0; i < 8; i++) begin
      single_mode = VEC[i][4]; phase_wr = VEC[i][3]; xfer_active = 1'b0;
      wr(1'b1, (int'(VEC[i][1]) << 5) | (int'(VEC[i][2]) << 4) | 1);
      xfer_active = 1'b1;
      @(negedge clk);
      chk(VEC[i][4] ? "R9 single" : (VEC[i][1] ? "R10 polarity" : "R8 phase"),
          ack, VEC[i][0]);
      xfer_active = 1'b0;
    end

    // disabled channel keeps idle
    single_mode = 1'b1;
    wr(1'b1, 'h00);
    xfer_active = 1'b1;
    @(negedge clk);
    chk("R12 idle when off", ack, 1);
    xfer_active = 1'b0;

    // instance without acknowledge configuration
    single_mode = 1'b0; phase_wr = 1'b0;
    wr(1'b1, 'h31);
    reg_sel = 1'b1; #0.5;
    chk("R11 bits read 0", int'(n_rdata), 'h01);
    xfer_active = 1'b1;
    @(negedge clk);
    chk("R11 read phase low", n_ack, 0);
    phase_wr = 1'b1;
    @(negedge clk);
    chk("R11 write phase idle", n_ack, 1);
    xfer_active = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule